// File: doc/BRIEF.md
# Synchronous Host Register Bus Slave

This block is the slave side of a synchronous processor bus. A host processor reaches a small internal register bank through it. Every control input is sampled on the rising edge of the bus clock. A transfer opens with a one-cycle active-high latch pulse while chip select is low, and that edge captures the address. Exactly one cycle later the host drives either the active-low write strobe or the active-low read strobe. The read data path comes from the captured address. The driver enable for the shared data bus is a purely combinational function of chip select and the read strobe, so an external tri-state buffer can be built from `data_out` and `data_oe`.

The block also runs two DMA channels. Software arms each channel through a control register. An armed channel raises its request output and keeps it high until the host answers on the matching active-low acknowledge input. A DMA write acknowledge loads the data bus into a receive register. A DMA read acknowledge presents a transmit register on the data bus. Neither acknowledge goes through the normal register path.

Top module: `hbus_slave`

## Requirements
- R1: On a rising edge where `ale` is 1 and `cs_n` is 0, `addr` is captured. Reads and writes in the following cycle use that captured address.
- R2: Writes and reads are done on the cycle after the latch pulse, while `cs_n` is 0 and the strobe is 0. Addresses 0 and 1 are read/write scratch registers. Address 3 is the read/write DMA transmit register. All of these are 16 bits wide.
- R3: A write strobe in a cycle that does not directly follow a latch pulse changes no register and raises no DMA request.
- R4: `data_oe` is 1 exactly while `cs_n` and `oe_n` are both 0. It follows those inputs combinationally, without waiting for a clock edge.
- R5: Reads from addresses 5 to 15 return zero, and writes to them are discarded. Address 4 is the DMA receive register. Host reads of it work, and host writes to it are discarded.
- R6: Address 2 is the DMA control register. Writing it with bit 0 set raises `dma_wr_req`, and writing it with bit 1 set raises `dma_rd_req`. Reading it returns `dma_wr_req` in bit 0, `dma_rd_req` in bit 1 and zero in every other bit.
- R7: `ack_wr_n` may be sampled at 0 while `dma_wr_req` is 1 and the cycle is not a strobe cycle. At that edge the receive register loads `data_in` and `dma_wr_req` clears.
- R8: `dma_rd_req` may be 1 while `ack_rd_n` is 0 outside a strobe cycle. During that cycle `data_out` shows the transmit register, and `dma_rd_req` clears at the next edge.
- R9: An acknowledge has no effect when its request is low, and none during a strobe cycle. A strobe cycle is the cycle right after a latch pulse.
- R10: A synchronous active-high `rst` clears all registers, both DMA requests and the captured address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low |
| ale | input | 1 | Address latch pulse, active high, one cycle |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Read strobe / output enable, active low |
| ack_wr_n | input | 1 | DMA write acknowledge, active low |
| ack_rd_n | input | 1 | DMA read acknowledge, active low |
| addr | input | 4 | Register address |
| data_in | input | 16 | Incoming data bus value |
| data_out | output | 16 | Outgoing data bus value |
| data_oe | output | 1 | Data bus driver enable |
| dma_wr_req | output | 1 | DMA write request |
| dma_rd_req | output | 1 | DMA read request |

## Verification
The assertions check several rules on every cycle:
- address capture on each latch pulse;
- that an orphan strobe leaves the transmit register and both requests alone;
- that each request clears after a valid acknowledge;
- that the receive register holds its value in every cycle without a valid write acknowledge;
- that the data bus carries transmit data during a DMA read;
- that the driver stays off unless both selects are low.

The bench scenarios show the things that are not single-cycle rules. These are:
- scratch contents surviving a mix of reads, writes and discarded accesses;
- the control register readback;
- an acknowledge held low through a strobe cycle;
- the state after a reset in mid-operation.

// File: rtl/hbus_pkg.sv
package hbus_pkg;

  // Address map derived from the number of scratch registers.
  function automatic int unsigned map_ctrl(int unsigned nscr);
    return nscr;
  endfunction

  function automatic int unsigned map_tx(int unsigned nscr);
    return nscr + 1;
  endfunction

  function automatic int unsigned map_rx(int unsigned nscr);
    return nscr + 2;
  endfunction

  // Control register bit positions.
  localparam int unsigned CTL_WR_BIT = 0;
  localparam int unsigned CTL_RD_BIT = 1;

endpackage

// File: rtl/hbus_phase.sv
module hbus_phase #(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_n,
  input  logic          ale,
  input  logic          we_n,
  input  logic [AW-1:0] addr,
  output logic [AW-1:0] addr_q,
  output logic          strobe_win,
  output logic          wr_evt
);

  logic latch_evt;
  assign latch_evt = ale && !cs_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q     <= '0;
      strobe_win <= 1'b0;
    end else begin
      strobe_win <= latch_evt;
      if (latch_evt) addr_q <= addr;
    end
  end

  assign wr_evt = strobe_win && !cs_n && !we_n;

endmodule

// File: rtl/hbus_dma_chan.sv
module hbus_dma_chan (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  input  logic ack_n,
  input  logic block,
  output logic req,
  output logic done
);

  assign done = req && !ack_n && !block;

  always_ff @(posedge clk) begin
    if (rst)       req <= 1'b0;
    else if (arm)  req <= 1'b1;
    else if (done) req <= 1'b0;
  end

endmodule

// File: rtl/hbus_regfile.sv
module hbus_regfile
  import hbus_pkg::*;
#(
  parameter int AW   = 4,
  parameter int DW   = 16,
  parameter int NSCR = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_evt,
  input  logic [AW-1:0] addr_q,
  input  logic [DW-1:0] wdata,
  input  logic          rx_load,
  input  logic          wr_req,
  input  logic          rd_req,
  output logic [DW-1:0] rd_data,
  output logic [DW-1:0] tx_q,
  output logic [DW-1:0] rx_q,
  output logic          arm_wr,
  output logic          arm_rd
);

  localparam logic [AW-1:0] A_CTRL = AW'(map_ctrl(NSCR));
  localparam logic [AW-1:0] A_TX   = AW'(map_tx(NSCR));
  localparam logic [AW-1:0] A_RX   = AW'(map_rx(NSCR));

  logic [DW-1:0] scr_q [NSCR];

  for (genvar g = 0; g < NSCR; g++) begin : g_scr
    always_ff @(posedge clk) begin
      if (rst) scr_q[g] <= '0;
      else if (wr_evt && addr_q == AW'(g)) scr_q[g] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) tx_q <= '0;
    else if (wr_evt && addr_q == A_TX) tx_q <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) rx_q <= '0;
    else if (rx_load) rx_q <= wdata;
  end

  assign arm_wr = wr_evt && addr_q == A_CTRL && wdata[CTL_WR_BIT];
  assign arm_rd = wr_evt && addr_q == A_CTRL && wdata[CTL_RD_BIT];

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NSCR; i++)
      if (addr_q == AW'(i)) rd_data = scr_q[i];
    if (addr_q == A_CTRL) begin
      rd_data[CTL_WR_BIT] = wr_req;
      rd_data[CTL_RD_BIT] = rd_req;
    end
    if (addr_q == A_TX) rd_data = tx_q;
    if (addr_q == A_RX) rd_data = rx_q;
  end

endmodule

// File: rtl/hbus_slave.sv
module hbus_slave #(
  parameter int AW   = 4,
  parameter int DW   = 16,
  parameter int NSCR = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_n,
  input  logic          ale,
  input  logic          we_n,
  input  logic          oe_n,
  input  logic          ack_wr_n,
  input  logic          ack_rd_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] data_in,
  output logic [DW-1:0] data_out,
  output logic          data_oe,
  output logic          dma_wr_req,
  output logic          dma_rd_req
);

  logic [AW-1:0] addr_q;
  logic          strobe_win;
  logic          wr_evt;
  logic          arm_wr, arm_rd;
  logic          wr_done, rd_done;
  logic [DW-1:0] rd_data, tx_q, rx_q;

  hbus_phase #(.AW(AW)) u_phase (
    .clk(clk), .rst(rst), .cs_n(cs_n), .ale(ale), .we_n(we_n),
    .addr(addr), .addr_q(addr_q), .strobe_win(strobe_win), .wr_evt(wr_evt)
  );

  hbus_dma_chan u_dwr (
    .clk(clk), .rst(rst), .arm(arm_wr), .ack_n(ack_wr_n),
    .block(strobe_win), .req(dma_wr_req), .done(wr_done)
  );

  hbus_dma_chan u_drd (
    .clk(clk), .rst(rst), .arm(arm_rd), .ack_n(ack_rd_n),
    .block(strobe_win), .req(dma_rd_req), .done(rd_done)
  );

  hbus_regfile #(.AW(AW), .DW(DW), .NSCR(NSCR)) u_regs (
    .clk(clk), .rst(rst), .wr_evt(wr_evt), .addr_q(addr_q), .wdata(data_in),
    .rx_load(wr_done), .wr_req(dma_wr_req), .rd_req(dma_rd_req),
    .rd_data(rd_data), .tx_q(tx_q), .rx_q(rx_q),
    .arm_wr(arm_wr), .arm_rd(arm_rd)
  );

  assign data_oe  = !cs_n && !oe_n;
  assign data_out = rd_done ? tx_q : rd_data;

endmodule

// File: rtl/hbus_slave_chk.sv
module hbus_slave_chk #(
  parameter int AW = 4,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          cs_n,
  input logic          ale,
  input logic          we_n,
  input logic          oe_n,
  input logic          ack_wr_n,
  input logic          ack_rd_n,
  input logic [AW-1:0] addr,
  input logic [AW-1:0] addr_q,
  input logic          strobe_win,
  input logic          wr_req,
  input logic          rd_req,
  input logic [DW-1:0] tx_q,
  input logic [DW-1:0] rx_q,
  input logic [DW-1:0] data_out,
  input logic          data_oe
);

  a_r1_addr_capture: assert property (@(posedge clk) disable iff (rst)
    (ale && !cs_n) |=> (addr_q == $past(addr)));

  a_r3_orphan_write: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && !we_n && !strobe_win) |=> ($stable(tx_q) && !$rose(wr_req) && !$rose(rd_req)));

  a_r4_no_drive: assert property (@(posedge clk) disable iff (rst)
    (cs_n || oe_n) |-> !data_oe);

  a_r7_wr_clear: assert property (@(posedge clk) disable iff (rst)
    (wr_req && !ack_wr_n && !strobe_win) |=> !wr_req);

  a_r8_rd_clear: assert property (@(posedge clk) disable iff (rst)
    (rd_req && !ack_rd_n && !strobe_win) |=> !rd_req);

  a_r8_rd_data: assert property (@(posedge clk) disable iff (rst)
    (rd_req && !ack_rd_n && !strobe_win) |-> (data_out == tx_q));

  a_r9_rx_hold: assert property (@(posedge clk) disable iff (rst)
    !(wr_req && !ack_wr_n && !strobe_win) |=> $stable(rx_q));

endmodule

bind hbus_slave hbus_slave_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .cs_n(cs_n), .ale(ale), .we_n(we_n), .oe_n(oe_n),
  .ack_wr_n(ack_wr_n), .ack_rd_n(ack_rd_n), .addr(addr), .addr_q(addr_q),
  .strobe_win(strobe_win), .wr_req(dma_wr_req), .rd_req(dma_rd_req),
  .tx_q(tx_q), .rx_q(rx_q), .data_out(data_out), .data_oe(data_oe)
);

// File: tb/sim_hbus_slave.sv
module sim_hbus_slave;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 4;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, ale = 1'b0, we_n = 1'b1, oe_n = 1'b1;
  logic ack_wr_n = 1'b1, ack_rd_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] data_in = '0;
  logic [DW-1:0] data_out;
  logic data_oe, dma_wr_req, dma_rd_req;

  int n_run = 0;
  int n_fail = 0;

  typedef struct {
    logic [DW-1:0] exp;
    string         tag;
  } exp_t;
  exp_t sbq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  hbus_slave #(.AW(AW), .DW(DW), .NSCR(2)) u0 (
    .clk(clk), .rst(rst), .cs_n(cs_n), .ale(ale), .we_n(we_n), .oe_n(oe_n),
    .ack_wr_n(ack_wr_n), .ack_rd_n(ack_rd_n), .addr(addr), .data_in(data_in),
    .data_out(data_out), .data_oe(data_oe),
    .dma_wr_req(dma_wr_req), .dma_rd_req(dma_rd_req)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Monitor: every driven bus cycle pops one expected value.
  always @(negedge clk) begin
    if (!rst && data_oe === 1'b1) begin
      if (sbq.size() == 0) begin
        check("R4 unexpected bus drive", 32'(data_oe), 32'd0);
      end else begin
        exp_t e;
        e = sbq.pop_front();
        check(e.tag, 32'(data_out), 32'(e.exp));
      end
    end
  end

  task automatic bus_write(logic [AW-1:0] a, logic [DW-1:0] d);
    @(posedge clk); #1 cs_n = 0; ale = 1; addr = a;
    @(posedge clk); #1 ale = 0; we_n = 0; data_in = d;
    @(posedge clk); #1 cs_n = 1; we_n = 1;
  endtask

  task automatic bus_read(logic [AW-1:0] a, logic [DW-1:0] e, string tag);
    sbq.push_back('{exp: e, tag: tag});
    @(posedge clk); #1 cs_n = 0; ale = 1; addr = a;
    @(posedge clk); #1 ale = 0; oe_n = 0;
    @(posedge clk); #1 cs_n = 1; oe_n = 1;
  endtask

  task automatic dma_write(logic [DW-1:0] d);
    @(posedge clk); #1 ack_wr_n = 0; data_in = d;
    @(posedge clk); #1 ack_wr_n = 1;
  endtask

  task automatic dma_read(logic [DW-1:0] e, string tag);
    sbq.push_back('{exp: e, tag: tag});
    @(posedge clk); #1 cs_n = 0; oe_n = 0; ack_rd_n = 0;
    @(posedge clk); #1 cs_n = 1; oe_n = 1; ack_rd_n = 1;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    check("watchdog expired", 32'd1, 32'd0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 0;
    // R10 reset state
    check("R10 data_oe after reset", 32'(data_oe), 32'd0);
    check("R10 wr_req after reset", 32'(dma_wr_req), 32'd0);
    check("R10 rd_req after reset", 32'(dma_rd_req), 32'd0);
    bus_read(4'd0, 16'h0000, "R10 scratch0 after reset");
    bus_read(4'd2, 16'h0000, "R6 ctrl after reset");

    // R1 R2 register access, several patterns
    bus_write(4'd0, 16'hA5C3);
    bus_write(4'd1, 16'h5A3C);
    bus_write(4'd3, 16'hFFFF);
    bus_read(4'd0, 16'hA5C3, "R2 scratch0");
    bus_read(4'd1, 16'h5A3C, "R1 scratch1 via latched addr");
    bus_read(4'd3, 16'hFFFF, "R2 tx reg");
    bus_write(4'd0, 16'h0001);
    bus_read(4'd0, 16'h0001, "R2 scratch0 rewrite");

    // R5 unmapped and read-only
    bus_write(4'd7, 16'h1234);
    bus_read(4'd7, 16'h0000, "R5 unmapped read zero");
    bus_read(4'd15, 16'h0000, "R5 top unmapped read zero");
    bus_read(4'd0, 16'h0001, "R5 unmapped write discarded");
    bus_write(4'd4, 16'hBEEF);
    bus_read(4'd4, 16'h0000, "R5 rx host write discarded");

    // R3 orphan strobe (latched address is 4 from last read? use scratch0)
    bus_read(4'd0, 16'h0001, "R3 prime latched addr");
    @(posedge clk); #1 cs_n = 0; we_n = 0; data_in = 16'hDEAD;
    @(posedge clk); #1 cs_n = 1; we_n = 1;
    bus_read(4'd0, 16'h0001, "R3 orphan write ignored");

    // R4 combinational enable
    @(posedge clk); #1 cs_n = 1; oe_n = 0;
    #1 check("R4 oe low cs high no drive", 32'(data_oe), 32'd0);
    cs_n = 0; oe_n = 1;
    #1 check("R4 cs low oe high no drive", 32'(data_oe), 32'd0);
    cs_n = 1;

    // R9 ack with nothing pending
    dma_write(16'h7777);
    bus_read(4'd4, 16'h0000, "R9 ack without request ignored");

    // R6 R7 DMA write
    bus_write(4'd2, 16'h0001);
    check("R6 wr_req raised", 32'(dma_wr_req), 32'd1);
    check("R6 rd_req stays low", 32'(dma_rd_req), 32'd0);
    bus_read(4'd2, 16'h0001, "R6 ctrl readback wr");

    // R9 ack held during a strobe cycle is ignored
    @(posedge clk); #1 cs_n = 0; ale = 1; addr = 4'd1;
    @(posedge clk); #1 ale = 0; we_n = 0; data_in = 16'h0F0F; ack_wr_n = 0;
    @(posedge clk); #1 cs_n = 1; we_n = 1; ack_wr_n = 1;
    check("R9 wr_req kept in strobe cycle", 32'(dma_wr_req), 32'd1);
    bus_read(4'd4, 16'h0000, "R9 rx unchanged in strobe cycle");
    bus_read(4'd1, 16'h0F0F, "R2 scratch1 written alongside ack");

    dma_write(16'hC0DE);
    check("R7 wr_req cleared", 32'(dma_wr_req), 32'd0);
    bus_read(4'd4, 16'hC0DE, "R7 rx loaded by dma");

    // R8 DMA read
    bus_write(4'd3, 16'h9876);
    bus_write(4'd2, 16'h0002);
    check("R6 rd_req raised", 32'(dma_rd_req), 32'd1);
    bus_read(4'd2, 16'h0002, "R6 ctrl readback rd");
    dma_read(16'h9876, "R8 dma read data");
    check("R8 rd_req cleared", 32'(dma_rd_req), 32'd0);

    // R10 reset in mid-operation
    bus_write(4'd2, 16'h0003);
    @(posedge clk); #1 rst = 1;
    @(posedge clk); #1 rst = 0;
    check("R10 wr_req cleared by reset", 32'(dma_wr_req), 32'd0);
    check("R10 rd_req cleared by reset", 32'(dma_rd_req), 32'd0);
    bus_read(4'd0, 16'h0000, "R10 scratch0 cleared");
    bus_read(4'd3, 16'h0000, "R10 tx cleared");
    bus_read(4'd4, 16'h0000, "R10 rx cleared");

    repeat (2) @(posedge clk);
    check("scoreboard drained", 32'(sbq.size()), 32'd0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule